// File: doc/BRIEF.md
# Virtual Function BAR Decoder

This block sits in a physical function that exposes many virtual functions (VFs) through one shared memory window. Software programs a window base, a per-VF slice size (as a power-of-two exponent), a count of enabled VFs, a first-VF routing offset and a routing stride. After that, every incoming memory request address is compared against the whole window. When the address falls inside the slice of an enabled VF, the block reports a hit, the VF index, the byte offset inside that VF's slice and the routing ID of that VF.

The window is cut into equal slices. VF n owns the bytes from base + n * size up to base + (n + 1) * size - 1. Because the size is a power of two, the index and the offset are bit fields of (address - base), so no divider is needed. Routing IDs begin at the physical function's own ID plus the first-VF offset and grow by the stride for each VF. If alternative routing-ID interpretation is not enabled, a VF whose function number would exceed 7 cannot be reached.

The enabled count follows a strict change rule. It can only move from zero to a value, or from a value back to zero. Requests for a count above the fixed maximum are refused as well. Every refused write raises a sticky error flag, which software clears explicitly.

Top module: `vf_bar_decoder`

## Requirements
- R1: While reset is held and right after it ends, hit_o, vf_num_o, vf_off_o, vf_rid_o and cnt_err_o are all zero. The enabled count and the enable bit are zero.
- R2: When cfg_we is high, cfg_sel picks the field that takes cfg_wdata: 0 window base, 1 slice size exponent (low 5 bits), 3 first-VF offset (low 16 bits), 4 stride (low 16 bits), 5 enable (bit 0). A written value applies to requests presented from the next clock cycle onward.
- R3: For an accepted request at address A, the outputs on the clock edge after the request show vf_num_o = (A - base) >> exponent and vf_off_o = (A - base) mod 2^exponent.
- R4: On a hit, vf_rid_o = (pf_rid + first offset + vf_num * stride) mod 2^16.
- R5: A write with cfg_sel = 2 sets the enabled count. If the current count is nonzero and the written value is nonzero, the write is refused: the count keeps its old value and cnt_err_o goes high.
- R6: A count write whose value is greater than TOTAL_VFS is refused: the count is unchanged and cnt_err_o goes high.
- R7: A write with cfg_sel = 6 and bit 0 set clears cnt_err_o. The same write with bit 0 clear leaves it unchanged.
- R8: A request is a miss if its address is below the base, or if its computed VF index is equal to or greater than the enabled count.
- R9: With the enable bit clear, or with req_vld low, no hit is reported.
- R10: If ari_en is low, a VF whose function number pf_rid[2:0] + first offset + vf_num * stride is greater than 7 is a miss.
- R11: On a miss, hit_o is 0 and vf_num_o, vf_off_o and vf_rid_o are all 0.
- R12: total_vfs_o always shows TOTAL_VFS, and initial_vfs_o always shows INITIAL_VFS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration field select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| ari_en | input | 1 | Allows function numbers above 7 |
| pf_rid | input | RID_W | Routing ID of the physical function |
| req_vld | input | 1 | Request address valid |
| req_addr | input | ADDR_W | Request address |
| hit_o | output | 1 | Request hit an enabled VF slice |
| vf_num_o | output | VF_W | Index of the VF that was hit |
| vf_off_o | output | ADDR_W | Byte offset inside the VF slice |
| vf_rid_o | output | RID_W | Routing ID of the VF that was hit |
| cnt_err_o | output | 1 | Sticky flag for a refused count write |
| total_vfs_o | output | VF_W | Fixed maximum VF count |
| initial_vfs_o | output | VF_W | Fixed initial VF count |

## Verification
The configuration registers can only be observed through the decode, so a wrong stored value shows up on the outputs one clock after the first request that depends on it. If a count write is wrongly accepted, a VF index that should miss will hit, or the reverse. If a count write is wrongly refused or applied, cnt_err_o is wrong on the next cycle. A bad exponent or base moves the boundaries between VFs. This is why the bench probes the first and last byte of each slice and the address just below the base.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  // Field codes for the configuration write port.
  typedef enum logic [2:0] {
    FLD_BASE   = 3'd0,
    FLD_SIZE   = 3'd1,
    FLD_COUNT  = 3'd2,
    FLD_OFFSET = 3'd3,
    FLD_STRIDE = 3'd4,
    FLD_CTRL   = 3'd5,
    FLD_ERRCLR = 3'd6,
    FLD_NONE   = 3'd7
  } cfg_field_e;

endpackage

// File: rtl/vfd_rst_sync.sv
module vfd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  // Reset enters at once and leaves two clock edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/vfd_cfg_regs.sv
module vfd_cfg_regs
  import vfd_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int VF_W      = 8,
  parameter int RID_W     = 16,
  parameter int SZ_W      = 5,
  parameter int TOTAL_VFS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base_o,
  output logic [SZ_W-1:0]   sz_log2_o,
  output logic [VF_W-1:0]   num_vfs_o,
  output logic [RID_W-1:0]  first_off_o,
  output logic [RID_W-1:0]  stride_o,
  output logic              vf_en_o,
  output logic              cnt_err_o
);

  localparam logic [ADDR_W-1:0] TOTAL_W = ADDR_W'(TOTAL_VFS);

  cfg_field_e fld;
  assign fld = cfg_field_e'(sel);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [SZ_W-1:0]   sz_q, sz_d;
  logic [VF_W-1:0]   num_q, num_d;
  logic [RID_W-1:0]  off_q, off_d;
  logic [RID_W-1:0]  str_q, str_d;
  logic              en_q, en_d;
  logic              err_q, err_d;
  logic              cnt_wr, cnt_reject;

  assign cnt_wr     = we && (fld == FLD_COUNT);
  // A nonzero count may not replace another nonzero count, and no count may pass the maximum.
  assign cnt_reject = (wdata > TOTAL_W) ||
                      ((num_q != '0) && (wdata != '0));

  always_comb begin
    base_d = base_q;
    sz_d   = sz_q;
    num_d  = num_q;
    off_d  = off_q;
    str_d  = str_q;
    en_d   = en_q;
    err_d  = err_q;
    if (we) begin
      unique case (fld)
        FLD_BASE:   base_d = wdata;
        FLD_SIZE:   sz_d   = wdata[SZ_W-1:0];
        FLD_COUNT: begin
          if (cnt_reject) err_d = 1'b1;
          else            num_d = wdata[VF_W-1:0];
        end
        FLD_OFFSET: off_d  = wdata[RID_W-1:0];
        FLD_STRIDE: str_d  = wdata[RID_W-1:0];
        FLD_CTRL:   en_d   = wdata[0];
        FLD_ERRCLR: if (wdata[0]) err_d = 1'b0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sz_q   <= '0;
      num_q  <= '0;
      off_q  <= '0;
      str_q  <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      base_q <= base_d;
      sz_q   <= sz_d;
      num_q  <= num_d;
      off_q  <= off_d;
      str_q  <= str_d;
      en_q   <= en_d;
      err_q  <= err_d;
    end
  end

  assign base_o      = base_q;
  assign sz_log2_o   = sz_q;
  assign num_vfs_o   = num_q;
  assign first_off_o = off_q;
  assign stride_o    = str_q;
  assign vf_en_o     = en_q;
  assign cnt_err_o   = err_q;

  // R5: a nonzero count written over a nonzero count leaves the count alone and flags the error.
  a_r5_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 3'd2 && num_q != '0 && wdata != '0) |=> ($stable(num_q) && err_q));

  // R6: the stored count never goes above the maximum.
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(ADDR_W-VF_W){1'b0}}, num_q} <= TOTAL_W));

  // R7: writing bit 0 set to the clear field drops the error flag.
  a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == 3'd6 && wdata[0]) |=> !err_q);

endmodule

// File: rtl/vfd_decode.sv
module vfd_decode #(
  parameter int ADDR_W = 32,
  parameter int VF_W   = 8,
  parameter int RID_W  = 16,
  parameter int SZ_W   = 5
) (
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [SZ_W-1:0]   sz_log2,
  input  logic [VF_W-1:0]   num_vfs,
  input  logic [RID_W-1:0]  first_off,
  input  logic [RID_W-1:0]  stride,
  input  logic              vf_en,
  input  logic              ari_en,
  input  logic [RID_W-1:0]  pf_rid,
  output logic              hit,
  output logic [VF_W-1:0]   vf_num,
  output logic [ADDR_W-1:0] vf_off,
  output logic [RID_W-1:0]  vf_rid
);

  // Wide enough for pf function bits + offset + index * stride without wrap.
  localparam int FN_W = RID_W + VF_W + 2;
  localparam logic [FN_W-1:0] LEGACY_MAX_FN = FN_W'(7);

  logic [ADDR_W-1:0] diff, idx_full, slice_mask;
  logic              below_base, in_range, ari_ok;
  logic [FN_W-1:0]   step, fn_wide, rid_wide;

  always_comb begin
    below_base = req_addr < base;
    diff       = req_addr - base;
    idx_full   = diff >> sz_log2;
    slice_mask = (ADDR_W'(1) << sz_log2) - ADDR_W'(1);
    in_range   = !below_base && (idx_full < ADDR_W'(num_vfs));

    step     = FN_W'(idx_full[VF_W-1:0]) * FN_W'(stride);
    fn_wide  = FN_W'(pf_rid[2:0]) + FN_W'(first_off) + step;
    rid_wide = FN_W'(pf_rid) + FN_W'(first_off) + step;
    ari_ok   = ari_en || (fn_wide <= LEGACY_MAX_FN);

    hit    = req_vld && vf_en && in_range && ari_ok;
    vf_num = hit ? idx_full[VF_W-1:0] : '0;
    vf_off = hit ? (diff & slice_mask) : '0;
    vf_rid = hit ? rid_wide[RID_W-1:0] : '0;
  end

endmodule

// File: rtl/vf_bar_decoder.sv
module vf_bar_decoder #(
  parameter int ADDR_W      = 32,
  parameter int VF_W        = 8,
  parameter int RID_W       = 16,
  parameter int SZ_W        = 5,
  parameter int TOTAL_VFS   = 16,
  parameter int INITIAL_VFS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              ari_en,
  input  logic [RID_W-1:0]  pf_rid,
  input  logic              req_vld,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit_o,
  output logic [VF_W-1:0]   vf_num_o,
  output logic [ADDR_W-1:0] vf_off_o,
  output logic [RID_W-1:0]  vf_rid_o,
  output logic              cnt_err_o,
  output logic [VF_W-1:0]   total_vfs_o,
  output logic [VF_W-1:0]   initial_vfs_o
);

  logic              rst_n_i;
  logic [ADDR_W-1:0] base;
  logic [SZ_W-1:0]   sz_log2;
  logic [VF_W-1:0]   num_vfs;
  logic [RID_W-1:0]  first_off, stride;
  logic              vf_en;
  logic              dec_hit;
  logic [VF_W-1:0]   dec_vf;
  logic [ADDR_W-1:0] dec_off;
  logic [RID_W-1:0]  dec_rid;

  vfd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  vfd_cfg_regs #(
    .ADDR_W(ADDR_W), .VF_W(VF_W), .RID_W(RID_W), .SZ_W(SZ_W), .TOTAL_VFS(TOTAL_VFS)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .we          (cfg_we),
    .sel         (cfg_sel),
    .wdata       (cfg_wdata),
    .base_o      (base),
    .sz_log2_o   (sz_log2),
    .num_vfs_o   (num_vfs),
    .first_off_o (first_off),
    .stride_o    (stride),
    .vf_en_o     (vf_en),
    .cnt_err_o   (cnt_err_o)
  );

  vfd_decode #(
    .ADDR_W(ADDR_W), .VF_W(VF_W), .RID_W(RID_W), .SZ_W(SZ_W)
  ) u_dec (
    .req_vld   (req_vld),
    .req_addr  (req_addr),
    .base      (base),
    .sz_log2   (sz_log2),
    .num_vfs   (num_vfs),
    .first_off (first_off),
    .stride    (stride),
    .vf_en     (vf_en),
    .ari_en    (ari_en),
    .pf_rid    (pf_rid),
    .hit       (dec_hit),
    .vf_num    (dec_vf),
    .vf_off    (dec_off),
    .vf_rid    (dec_rid)
  );

  // Output stage: the register always loads, so its enable is tied high.
  logic              out_ce;
  logic              hit_q;
  logic [VF_W-1:0]   vf_q;
  logic [ADDR_W-1:0] off_q;
  logic [RID_W-1:0]  rid_q;

  assign out_ce = 1'b1;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      hit_q <= 1'b0;
      vf_q  <= '0;
      off_q <= '0;
      rid_q <= '0;
    end else if (out_ce) begin
      hit_q <= dec_hit;
      vf_q  <= dec_vf;
      off_q <= dec_off;
      rid_q <= dec_rid;
    end
  end

  assign hit_o         = hit_q;
  assign vf_num_o      = vf_q;
  assign vf_off_o      = off_q;
  assign vf_rid_o      = rid_q;
  assign total_vfs_o   = VF_W'(TOTAL_VFS);
  assign initial_vfs_o = VF_W'(INITIAL_VFS);

  // R11: a miss shows zeros on every decode output.
  a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_n_i)
    !hit_o |-> (vf_num_o == '0 && vf_off_o == '0 && vf_rid_o == '0));

  // R8: the reported index was below the count that was active when the request was sampled.
  a_r8_vf_below_count: assert property (@(posedge clk) disable iff (!rst_n_i)
    hit_o |-> (vf_num_o < $past(num_vfs)));

  // R9: without a valid request in the previous cycle, nothing hits.
  a_r9_no_req_no_hit: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$past(req_vld) |-> !hit_o);

  // R9: with the capability disabled in the previous cycle, nothing hits.
  a_r9_disabled_no_hit: assert property (@(posedge clk) disable iff (!rst_n_i)
    !$past(vf_en) |-> !hit_o);

endmodule

// File: tb/vf_bar_decoder_bench.sv
module vf_bar_decoder_bench;

  localparam int CLK_P     = 10;
  localparam int ADDR_W    = 32;
  localparam int VF_W      = 8;
  localparam int RID_W     = 16;
  localparam int TOTAL_VFS = 16;
  localparam int INIT_VFS  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_we;
  logic [2:0]        cfg_sel;
  logic [ADDR_W-1:0] cfg_wdata;
  logic              ari_en;
  logic [RID_W-1:0]  pf_rid;
  logic              req_vld;
  logic [ADDR_W-1:0] req_addr;
  logic              hit_o;
  logic [VF_W-1:0]   vf_num_o;
  logic [ADDR_W-1:0] vf_off_o;
  logic [RID_W-1:0]  vf_rid_o;
  logic              cnt_err_o;
  logic [VF_W-1:0]   total_vfs_o, initial_vfs_o;

  always #(CLK_P/2) clk = ~clk;

  vf_bar_decoder #(.TOTAL_VFS(TOTAL_VFS), .INITIAL_VFS(INIT_VFS)) u_vf_bar_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .ari_en(ari_en), .pf_rid(pf_rid), .req_vld(req_vld), .req_addr(req_addr),
    .hit_o(hit_o), .vf_num_o(vf_num_o), .vf_off_o(vf_off_o), .vf_rid_o(vf_rid_o),
    .cnt_err_o(cnt_err_o), .total_vfs_o(total_vfs_o), .initial_vfs_o(initial_vfs_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Bench-side model of the programmed state, built from the requirements.
  bit [63:0] m_base, m_sz, m_cnt, m_off, m_str;
  bit        m_en, m_err;

  task automatic check(input string req, input bit [63:0] act, input bit [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit [2:0] sel, input bit [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
    case (sel)
      3'd0: m_base = data;
      3'd1: m_sz   = data & 32'h1f;
      3'd2: begin
        if (data > TOTAL_VFS || (m_cnt != 0 && data != 0)) m_err = 1'b1;
        else m_cnt = data;
      end
      3'd3: m_off = data & 32'hffff;
      3'd4: m_str = data & 32'hffff;
      3'd5: m_en  = data[0];
      3'd6: if (data[0]) m_err = 1'b0;
      default: ;
    endcase
  endtask

  // Expected decode for address a with the model state.
  task automatic expect_dec(input bit [31:0] a, input bit v,
                            output bit e_hit, output bit [63:0] e_vf,
                            output bit [63:0] e_off, output bit [63:0] e_rid);
    bit [63:0] diff, idx, fn;
    e_hit = 0; e_vf = 0; e_off = 0; e_rid = 0;
    if (v && m_en && a >= m_base) begin
      diff = a - m_base;
      idx  = diff >> m_sz;
      if (idx < m_cnt) begin
        fn = (pf_rid & 16'h7) + m_off + idx * m_str;
        if (ari_en || fn <= 7) begin
          e_hit = 1;
          e_vf  = idx;
          e_off = diff & ((64'd1 << m_sz) - 1);
          e_rid = (pf_rid + m_off + idx * m_str) & 64'hffff;
        end
      end
    end
  endtask

  task automatic req(input string tag, input bit [31:0] a, input bit v);
    bit e_hit; bit [63:0] e_vf, e_off, e_rid;
    expect_dec(a, v, e_hit, e_vf, e_off, e_rid);
    req_vld = v; req_addr = a;
    @(negedge clk);
    req_vld = 1'b0;
    check({tag, " hit"}, hit_o, e_hit);
    check({tag, " vf"},  vf_num_o, e_vf);
    check({tag, " off"}, vf_off_o, e_off);
    check({tag, " rid"}, vf_rid_o, e_rid);
  endtask

  bit done = 0;

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    ari_en = 1'b1; pf_rid = 16'h0100; req_vld = 0; req_addr = 0;
    m_base = 0; m_sz = 0; m_cnt = 0; m_off = 0; m_str = 0; m_en = 0; m_err = 0;
    repeat (3) @(negedge clk);
    // R1: outputs are zero during reset
    check("R1 hit in reset", hit_o, 0);
    check("R1 err in reset", cnt_err_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 vf after reset", vf_num_o, 0);
    check("R1 rid after reset", vf_rid_o, 0);
    // R12: fixed counts
    check("R12 total", total_vfs_o, TOTAL_VFS);
    check("R12 initial", initial_vfs_o, INIT_VFS);

    // R2: program fields, then enable
    wr(3'd0, 32'h4000_0000);
    wr(3'd1, 32'd12);
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd1);
    wr(3'd2, 32'd4);
    req("R9 not enabled", 32'h4000_0000, 1);
    wr(3'd5, 32'd1);
    // R3, R4: first and last byte of slices
    req("R3 vf0 first", 32'h4000_0000, 1);
    req("R3 vf3 last",  32'h4000_3fff, 1);
    req("R4 vf2 mid",   32'h4000_2abc, 1);
    // R8: past the enabled count and below base
    req("R8 vf4 miss",  32'h4000_4000, 1);
    req("R8 below base", 32'h3fff_ffff, 1);
    // R9: no valid request
    req("R9 no req",    32'h4000_1000, 0);

    // R5: nonzero over nonzero refused
    wr(3'd2, 32'd6);
    check("R5 err set", cnt_err_o, 1);
    req("R5 vf5 still miss", 32'h4000_5000, 1);
    req("R5 vf3 still hit",  32'h4000_3000, 1);
    // R7: bit0 clear has no effect, bit0 set clears
    wr(3'd6, 32'd0);
    check("R7 err kept", cnt_err_o, 1);
    wr(3'd6, 32'd1);
    check("R7 err cleared", cnt_err_o, 0);
    // R6: over maximum refused
    wr(3'd2, 32'd0);
    wr(3'd2, TOTAL_VFS + 1);
    check("R6 err set", cnt_err_o, 1);
    req("R6 count still zero", 32'h4000_0000, 1);
    wr(3'd6, 32'd1);
    wr(3'd2, TOTAL_VFS);
    check("R6 max accepted", cnt_err_o, 0);
    req("R6 last vf hit", 32'h4000_f000, 1);

    // R10: legacy function limit
    ari_en = 1'b0;
    wr(3'd3, 32'd7);
    req("R10 fn7 hit",  32'h4000_0010, 1);
    req("R10 fn8 miss", 32'h4000_1010, 1);
    ari_en = 1'b1;
    req("R10 fn8 ari hit", 32'h4000_1010, 1);

    // R9: disable stops hits
    wr(3'd5, 32'd0);
    req("R9 disabled", 32'h4000_0000, 1);
    wr(3'd5, 32'd1);

    // Random configs and requests, checked against the model (R3 R4 R8 R10 R11)
    for (int cfg = 0; cfg < 12; cfg++) begin
      wr(3'd2, 32'd0);
      wr(3'd0, $urandom & 32'h7fff_0000);
      wr(3'd1, 12 + ($urandom % 5));
      wr(3'd3, $urandom % 9);
      wr(3'd4, 1 + ($urandom % 4));
      wr(3'd2, $urandom % (TOTAL_VFS + 1));
      ari_en = $urandom % 2;
      pf_rid = 16'($urandom);
      for (int k = 0; k < 25; k++) begin
        bit [63:0] vf, off, a;
        vf  = $urandom % (m_cnt + 3);
        off = $urandom & ((64'd1 << m_sz) - 1);
        if ($urandom % 10 == 0) a = m_base - 1 - ($urandom % 256);
        else a = m_base + (vf << m_sz) + off;
        req("R3 random", a[31:0], ($urandom % 8) != 0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule